// File: doc/BRIEF.md
# Timed Trace Equivalence Checker

This block decides, while the traces are still being produced, whether two models of the same component behave alike. Each model feeds its own event stream. An event is one step of the trace and carries a vector of Boolean outputs and a set of signed integer outputs. The block stamps each event with the current value of a time counter that belongs to that stream. Both counters advance on one shared time-unit tick.

Events are paired by order of arrival. The k-th event of stream A is judged against the k-th event of stream B. Boolean outputs must match exactly. The difference of the two timestamps and the difference of each integer output must each fall inside its own programmable signed window, so a zero-width window gives strict equality. Each stream holds its pending events in a short queue, so one model may run ahead of the other. A judgement is made as soon as both queue heads are present.

A result pulse reports every judged pair. A sticky flag latches the first disagreement, and the index of that pair is kept. In cyclic mode, a cycle-start marker that arrives with an event restarts that stream's time reference. This keeps slow drift from building up across cycles.

Top module: `trace_cmp`

## Requirements
- R1: After reset, cmp_vld_o, cmp_ok_o, mismatch_o, ovf_o and fail_idx_o are all zero, and both time counters are zero.
- R2: In global mode, the timestamp of an event is the number of tick_i cycles that the stream's counter has seen since reset. The counter is cleared only by reset.
- R3: The k-th event of A is paired with the k-th event of B. A pair is judged in the first cycle in which both queue heads hold an event. cmp_vld_o is high for exactly one cycle, in the cycle after that judgement. No pulse occurs while only one stream has an event pending.
- R4: The Boolean vector of the two events must be bit-for-bit equal, or cmp_ok_o is 0.
- R5: The time difference tA - tB is formed as a (TW+1)-bit signed value. It must satisfy dt_lo_i <= tA - tB <= dt_hi_i, with both bounds inclusive.
- R6: Integer variable k sits at bits [k*IW +: IW] of the integer bus, in two's complement. Its difference vA - vB is formed as an (IW+1)-bit signed value, so that no value overflows. The difference must lie within [lo_k, hi_k]. Here lo_k is bits [k*(IW+1) +: IW+1] of dv_lo_i and hi_k is the same bits of dv_hi_i, both signed.
- R7: cmp_ok_o is 1 only when the Boolean, time and every integer condition all hold for the pair.
- R8: When cyc_mode_i is 1, a mark input that is high restarts that stream's counter. The event of that cycle is stamped 0, and counting resumes from 0. When cyc_mode_i is 0, mark inputs have no effect.
- R9: mismatch_o rises with the first failing pair and stays high until reset. fail_idx_o holds the 0-based index of that pair and does not change on later failures.
- R10: Each stream queues up to DEPTH events (default 8). An event that arrives while its queue is full, and no pair is judged in that cycle, is dropped. The drop sets ovf_o, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Shared time-unit tick; each high cycle advances both counters |
| cyc_mode_i | input | 1 | 1 selects cyclic mode, 0 selects global mode |
| a_vld_i | input | 1 | Stream A event strobe |
| a_mark_i | input | 1 | Stream A cycle-start marker |
| a_bool_i | input | NB | Stream A Boolean outputs |
| a_int_i | input | NI*IW | Stream A integer outputs, variable k at [k*IW +: IW] |
| b_vld_i | input | 1 | Stream B event strobe |
| b_mark_i | input | 1 | Stream B cycle-start marker |
| b_bool_i | input | NB | Stream B Boolean outputs |
| b_int_i | input | NI*IW | Stream B integer outputs |
| dt_lo_i | input | TW+1 | Lower bound of tA - tB, signed |
| dt_hi_i | input | TW+1 | Upper bound of tA - tB, signed |
| dv_lo_i | input | NI*(IW+1) | Per-variable lower bounds of vA - vB, signed |
| dv_hi_i | input | NI*(IW+1) | Per-variable upper bounds of vA - vB, signed |
| cmp_vld_o | output | 1 | One-cycle pulse for each judged pair |
| cmp_ok_o | output | 1 | Verdict of that pair, valid with cmp_vld_o |
| mismatch_o | output | 1 | Sticky: some pair has failed |
| fail_idx_o | output | IDXW | Index of the first failing pair |
| ovf_o | output | 1 | Sticky: an event was dropped on a full queue |

## Verification
A queue pointer or count that goes wrong would show as a pair judged with the wrong partner. It would also show as a missing or extra result pulse in the cycle after the second event of a pair lands. A dropped event shows only as a missing pulse once the lagging stream catches up. A time counter that fails to restart, or keeps a stale value, shows at once as a failing verdict on the next pair whose window has zero width. A sticky register that clears or reloads shows as a changed fail_idx_o after any later failing pair.

// File: rtl/trace_cmp_pkg.sv
package trace_cmp_pkg;
  localparam int NB_DEF    = 4;
  localparam int NI_DEF    = 2;
  localparam int IW_DEF    = 8;
  localparam int TW_DEF    = 16;
  localparam int DEPTH_DEF = 8;
  localparam int IDXW_DEF  = 16;

  typedef enum logic {
    MODE_GLOBAL = 1'b0,
    MODE_CYCLIC = 1'b1
  } tmode_e;
endpackage

// File: rtl/trace_cmp_stamp.sv
module trace_cmp_stamp #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          cyc_en_i,
  input  logic          mark_i,
  output logic [TW-1:0] stamp_o
);
  logic          restart;
  logic [TW-1:0] cnt_q;

  // restart acts before the tick of the same cycle
  assign restart = cyc_en_i & mark_i;
  assign stamp_o = restart ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= stamp_o + TW'(tick_i);
  end

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (cnt_q == TW'($past(tick_i))));
endmodule

// File: rtl/trace_cmp_fifo.sv
module trace_cmp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          full, accept;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign accept  = push_i & (~full | pop_i);
  assign dout_o  = mem[rd_q];

  always_ff @(posedge clk_i) begin
    if (accept) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (accept) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      unique case ({accept, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i & ~accept) ovf_o <= 1'b1;
    end
  end

  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_ovf_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/trace_cmp_judge.sv
module trace_cmp_judge #(
  parameter int NB = 4,
  parameter int NI = 2,
  parameter int IW = 8,
  parameter int TW = 16,
  localparam int W = NB + NI * IW + TW
) (
  input  logic [W-1:0]         a_w_i,
  input  logic [W-1:0]         b_w_i,
  input  logic signed [TW:0]   dt_lo_i,
  input  logic signed [TW:0]   dt_hi_i,
  input  logic [NI*(IW+1)-1:0] dv_lo_i,
  input  logic [NI*(IW+1)-1:0] dv_hi_i,
  output logic                 ok_o
);
  logic [NB-1:0]    a_bool, b_bool;
  logic [NI*IW-1:0] a_int, b_int;
  logic [TW-1:0]    a_t, b_t;
  logic signed [TW:0] dt;
  logic             t_ok;
  logic [NI-1:0]    v_ok;

  assign a_bool = a_w_i[W-1 -: NB];
  assign b_bool = b_w_i[W-1 -: NB];
  assign a_int  = a_w_i[TW +: NI*IW];
  assign b_int  = b_w_i[TW +: NI*IW];
  assign a_t    = a_w_i[TW-1:0];
  assign b_t    = b_w_i[TW-1:0];

  assign dt   = $signed({1'b0, a_t}) - $signed({1'b0, b_t});
  assign t_ok = (dt >= dt_lo_i) && (dt <= dt_hi_i);

  for (genvar k = 0; k < NI; k++) begin : g_var
    logic [IW-1:0]      av, bv;
    logic signed [IW:0] dv, lo, hi;
    assign av = a_int[k*IW +: IW];
    assign bv = b_int[k*IW +: IW];
    assign dv = $signed({av[IW-1], av}) - $signed({bv[IW-1], bv});
    assign lo = $signed(dv_lo_i[k*(IW+1) +: IW+1]);
    assign hi = $signed(dv_hi_i[k*(IW+1) +: IW+1]);
    assign v_ok[k] = (dv >= lo) && (dv <= hi);
  end

  assign ok_o = (a_bool == b_bool) && t_ok && (&v_ok);
endmodule

// File: rtl/trace_cmp.sv
module trace_cmp
  import trace_cmp_pkg::*;
#(
  parameter int NB    = NB_DEF,
  parameter int NI    = NI_DEF,
  parameter int IW    = IW_DEF,
  parameter int TW    = TW_DEF,
  parameter int DEPTH = DEPTH_DEF,
  parameter int IDXW  = IDXW_DEF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 cyc_mode_i,
  input  logic                 a_vld_i,
  input  logic                 a_mark_i,
  input  logic [NB-1:0]        a_bool_i,
  input  logic [NI*IW-1:0]     a_int_i,
  input  logic                 b_vld_i,
  input  logic                 b_mark_i,
  input  logic [NB-1:0]        b_bool_i,
  input  logic [NI*IW-1:0]     b_int_i,
  input  logic signed [TW:0]   dt_lo_i,
  input  logic signed [TW:0]   dt_hi_i,
  input  logic [NI*(IW+1)-1:0] dv_lo_i,
  input  logic [NI*(IW+1)-1:0] dv_hi_i,
  output logic                 cmp_vld_o,
  output logic                 cmp_ok_o,
  output logic                 mismatch_o,
  output logic [IDXW-1:0]      fail_idx_o,
  output logic                 ovf_o
);
  localparam int W = NB + NI * IW + TW;

  tmode_e         mode;
  logic           cyc_en, both, ok;
  logic [1:0]     vld_s, mark_s, empty_s, ovf_s;
  logic [W-1:0]   word_in  [2];
  logic [W-1:0]   word_out [2];
  logic [TW-1:0]  stamp_s  [2];
  logic [IDXW-1:0] idx_q;

  assign mode   = tmode_e'(cyc_mode_i);
  assign cyc_en = (mode == MODE_CYCLIC);
  assign vld_s  = {b_vld_i, a_vld_i};
  assign mark_s = {b_mark_i, a_mark_i};
  assign word_in[0] = {a_bool_i, a_int_i, stamp_s[0]};
  assign word_in[1] = {b_bool_i, b_int_i, stamp_s[1]};
  assign both   = ~empty_s[0] & ~empty_s[1];
  assign ovf_o  = |ovf_s;

  for (genvar s = 0; s < 2; s++) begin : g_strm
    trace_cmp_stamp #(.TW(TW)) u_stamp (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .cyc_en_i (cyc_en),
      .mark_i   (mark_s[s]),
      .stamp_o  (stamp_s[s])
    );
    trace_cmp_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (vld_s[s]),
      .pop_i   (both),
      .din_i   (word_in[s]),
      .dout_o  (word_out[s]),
      .empty_o (empty_s[s]),
      .ovf_o   (ovf_s[s])
    );
  end

  trace_cmp_judge #(.NB(NB), .NI(NI), .IW(IW), .TW(TW)) u_judge (
    .a_w_i   (word_out[0]),
    .b_w_i   (word_out[1]),
    .dt_lo_i (dt_lo_i),
    .dt_hi_i (dt_hi_i),
    .dv_lo_i (dv_lo_i),
    .dv_hi_i (dv_hi_i),
    .ok_o    (ok)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_vld_o  <= 1'b0;
      cmp_ok_o   <= 1'b0;
      mismatch_o <= 1'b0;
      fail_idx_o <= '0;
      idx_q      <= '0;
    end else begin
      cmp_vld_o <= both;
      cmp_ok_o  <= both & ok;
      if (both) begin
        idx_q <= idx_q + 1'b1;
        if (!ok && !mismatch_o) begin
          mismatch_o <= 1'b1;
          fail_idx_o <= idx_q;
        end
      end
    end
  end

  p_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_vld_o |-> $past(both));
  p_fail_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_vld_o && !cmp_ok_o) |-> mismatch_o);
  p_idx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |=> (mismatch_o && $stable(fail_idx_o)));
endmodule

// File: tb/sim_trace_cmp.sv
module sim_trace_cmp;
  localparam int CLK_P = 10;
  localparam int WD    = 50000;

  typedef struct packed {
    logic [3:0] ab, bb;
    logic [7:0] a0, b0, a1, b1;
    int         lag;   // >=0: A first then lag ticks; <0: B first
    logic       exp_ok;
    logic [3:0] req;
  } vec_t;

  // dt window [-2,1]; var0 window [0,0]; var1 window [-3,3]
  localparam vec_t VT [10] = '{
    '{4'h5, 4'h5, 8'd10, 8'd10, 8'hFC, 8'hFF,  0, 1'b1, 4'd6},
    '{4'hA, 4'hA, 8'hF9, 8'hF9, 8'h14, 8'h11,  2, 1'b1, 4'd5},
    '{4'h0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, -1, 1'b1, 4'd5},
    '{4'h3, 4'h2, 8'h00, 8'h00, 8'h00, 8'h00,  0, 1'b0, 4'd4},
    '{4'h1, 4'h1, 8'h00, 8'h00, 8'h00, 8'h00,  3, 1'b0, 4'd5},
    '{4'h1, 4'h1, 8'h00, 8'h00, 8'h64, 8'h60,  0, 1'b0, 4'd6},
    '{4'h1, 4'h1, 8'h01, 8'h00, 8'h00, 8'h00,  0, 1'b0, 4'd6},
    '{4'h1, 4'h1, 8'h00, 8'h00, 8'h00, 8'h00, -2, 1'b0, 4'd5},
    '{4'h1, 4'h1, 8'h00, 8'h00, 8'h80, 8'h7F,  0, 1'b0, 4'd6},
    '{4'hF, 4'hF, 8'h00, 8'h00, 8'h7F, 8'h7C,  1, 1'b1, 4'd7}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0, cyc_mode = 1'b0;
  logic a_vld = 1'b0, a_mark = 1'b0, b_vld = 1'b0, b_mark = 1'b0;
  logic [3:0]  a_bool = '0, b_bool = '0;
  logic [15:0] a_int = '0, b_int = '0;
  logic signed [16:0] dt_lo = '0, dt_hi = '0;
  logic [17:0] dv_lo = '0, dv_hi = '0;
  logic        cmp_vld, cmp_ok, mismatch, ovf;
  logic [15:0] fail_idx;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  trace_cmp u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cyc_mode_i(cyc_mode),
    .a_vld_i(a_vld), .a_mark_i(a_mark), .a_bool_i(a_bool), .a_int_i(a_int),
    .b_vld_i(b_vld), .b_mark_i(b_mark), .b_bool_i(b_bool), .b_int_i(b_int),
    .dt_lo_i(dt_lo), .dt_hi_i(dt_hi), .dv_lo_i(dv_lo), .dv_hi_i(dv_hi),
    .cmp_vld_o(cmp_vld), .cmp_ok_o(cmp_ok), .mismatch_o(mismatch),
    .fail_idx_o(fail_idx), .ovf_o(ovf)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic cyc(input logic av, input logic bv, input logic tk,
                     input logic am, input logic bm);
    @(negedge clk);
    a_vld = av; b_vld = bv; tick = tk; a_mark = am; b_mark = bm;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    end
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 cmp_vld", cmp_vld, 0);
    chk("R1 cmp_ok", cmp_ok, 0);
    chk("R1 mismatch", mismatch, 0);
    chk("R1 fail_idx", fail_idx, 0);
    chk("R1 ovf", ovf, 0);

    // table walk in global mode
    dt_lo = -17'sd2; dt_hi = 17'sd1;
    dv_lo = {9'h1FD, 9'h000}; dv_hi = {9'h003, 9'h000};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      a_bool = VT[i].ab; b_bool = VT[i].bb;
      a_int = {VT[i].a1, VT[i].a0}; b_int = {VT[i].b1, VT[i].b0};
      if (VT[i].lag >= 0) cyc(1, 0, 0, 0, 0);
      else                cyc(0, 1, 0, 0, 0);
      for (int t = 0; t < ((VT[i].lag < 0) ? -VT[i].lag : VT[i].lag); t++) begin
        cyc(0, 0, 1, 0, 0);
        if (t == 1) chk("R3 no pulse with one side pending", cmp_vld, 0);
      end
      if (VT[i].lag >= 0) cyc(0, 1, 0, 0, 0);
      else                cyc(1, 0, 0, 0, 0);
      cyc(0, 0, 0, 0, 0);
      @(negedge clk);
      chk("R3 pulse", cmp_vld, 1);
      chk(tag(VT[i].req), cmp_ok, VT[i].exp_ok);
      @(negedge clk);
      chk("R3 single pulse", cmp_vld, 0);
    end
    chk("R9 sticky", mismatch, 1);
    chk("R9 first index", fail_idx, 3);

    // R8 cyclic mode: A restarts, B keeps counting
    do_reset();
    cyc_mode = 1'b1;
    dt_lo = -17'sd5; dt_hi = -17'sd5;
    dv_lo = '0; dv_hi = '0;
    a_bool = 4'h6; b_bool = 4'h6; a_int = 16'h1234; b_int = 16'h1234;
    repeat (5) cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 marked event stamped 0", cmp_ok, 1);
    repeat (2) cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 count resumes from 0", cmp_ok, 1);
    chk("R8 no mismatch", mismatch, 0);

    // R8 global mode ignores marks; R2 absolute stamps
    do_reset();
    cyc_mode = 1'b0;
    dt_lo = '0; dt_hi = '0;
    repeat (5) cyc(0, 0, 1, 0, 0);
    cyc(1, 1, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 mark ignored in global mode", cmp_ok, 1);
    dt_lo = -17'sd3; dt_hi = -17'sd3;
    repeat (4) cyc(0, 0, 1, 0, 0);
    cyc(1, 0, 0, 0, 0);
    repeat (3) cyc(0, 0, 1, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R2 absolute stamps", cmp_ok, 1);

    // R10 overflow
    do_reset();
    repeat (8) cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R10 eight fit", ovf, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk("R10 ninth overflows", ovf, 1);
    begin
      int pulses = 0;
      for (int c = 0; c < 14; c++) begin
        cyc(0, (c < 8) ? 1'b1 : 1'b0, 0, 0, 0);
        if (cmp_vld) pulses++;
      end
      chk("R10 queued pairs", pulses, 8);
    end
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R10 dropped event not paired", cmp_vld, 0);
    chk("R10 ovf sticky", ovf, 1);

    summary();
    $finish;
  end
endmodule